// File: doc/BRIEF.md
# Alarm-Driven Output Clamp Controller

This block decides, for each of a number of analog gate-drive channels (two by default), whether the gate output follows its normal control path or is forced to an external clamp level. Software programs a 2-bit clamp mode per channel through a one-cycle rewrite pulse. An alarm line per channel reports a threshold violation. A companion flag tells the block whether that alarm came from measuring the gate voltage itself. A hardware safe pin per channel forces the clamp regardless of anything software has done.

The block builds only the decision logic and its stored state: the mode held per channel, a latch per channel, and one registered clamp-select output per channel. The analog switch, the sampling converter and the alarm comparators lie outside it. Mode code 3 latches the clamp on the first qualifying alarm and holds it until software rewrites the mode. Mode code 2 follows the alarm, except when the alarm comes from the gate voltage. In that case it latches, because clamping the same voltage it samples would otherwise form a loop.

Top module: `clamp_ctl_top`

## Requirements
- R1: After the active-low reset `rst_n` is released, every channel's `clamp_o` bit is 0, its stored mode is 0 and its latch is clear.
- R2: A channel's mode is taken from its 2-bit field of `cfg_mode_i` (bits [2c+1:2c] for channel c) in the cycle its `cfg_wr_i` bit is high. Mode 0 never produces an alarm clamp.
- R3: In mode 1, alarms never produce a clamp, whatever the state of `alarm_gate_i`.
- R4: In mode 3, an alarm sets the channel's latch, and `clamp_o` goes to 1 at the next clock edge. It stays at 1 in later cycles even after the alarm has cleared.
- R5: A latched clamp is released only by a rewrite pulse for that channel. After a rewrite of mode 3 or mode 1, `clamp_o` is 0 at the next edge unless the safe pin is high. A rewrite with any code clears the latch.
- R6: In mode 2 with `alarm_gate_i` low, `clamp_o` equals the alarm sampled at the previous edge, and it releases as soon as the alarm clears.
- R7: In mode 2 with `alarm_gate_i` high, an alarm latches the clamp exactly as mode 3 does.
- R8: When a channel's `safe_i` is high, that channel's `clamp_o` is 1 at the next edge, whatever its mode, latch or rewrite. When `safe_i` falls, the output again follows the mode and latch state, and a latch set earlier is still held.
- R9: In a cycle where a rewrite pulse and an alarm arrive together, the rewrite wins. The alarm neither sets the latch nor clamps the output in the next cycle.
- R10: Channels are independent. Alarms, rewrites and safe pins on one channel never change another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| safe_i | input | NCH | Hardware safe-mode pin per channel, forces the clamp |
| alarm_i | input | NCH | Alarm indication per channel |
| alarm_gate_i | input | NCH | Per channel: alarm source is the gate-voltage measurement |
| cfg_wr_i | input | NCH | One-cycle rewrite pulse per channel |
| cfg_mode_i | input | 2*NCH | Mode value carried by the rewrite pulse, 2 bits per channel |
| clamp_o | output | NCH | Registered clamp-select per channel |

## Verification
Every result of this block appears exactly one clock edge after the inputs that cause it. This holds for a new latch, a follow-mode release, a rewrite clearing the latch, and the safe pin taking hold. The bench drives the inputs at a falling edge and, for each step, pushes the expected outputs into a queue. At the next falling edge, one rising edge later, it pops that entry and compares it against the outputs. Latched behaviour is checked by holding idle steps after the alarm has cleared, so the same one-edge rule tests persistence.

// File: rtl/clamp_ctl_pkg.sv
package clamp_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_NOALM  = 2'd1,
        MODE_FOLLOW = 2'd2,
        MODE_LATCH  = 2'd3
    } clamp_mode_e;

    typedef struct packed {
        clamp_mode_e mode;
        logic        latched;
        logic        clamp;
    } chan_state_t;

endpackage

// File: rtl/clamp_mode_decode.sv
module clamp_mode_decode
    import clamp_ctl_pkg::*;
(
    input  clamp_mode_e mode_i,
    input  logic        gate_src_i,
    output logic        latch_en_o,
    output logic        follow_en_o
);

    always_comb begin
        latch_en_o  = 1'b0;
        follow_en_o = 1'b0;
        unique case (mode_i)
            MODE_LATCH:  latch_en_o = 1'b1;
            MODE_FOLLOW: begin
                // A gate-sourced alarm must not release, or the loop re-forms.
                latch_en_o  = gate_src_i;
                follow_en_o = ~gate_src_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/clamp_chan_core.sv
module clamp_chan_core
    import clamp_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       safe_i,
    input  logic       alarm_i,
    input  logic       alarm_gate_i,
    input  logic       wr_i,
    input  logic [1:0] wr_mode_i,
    output logic       clamp_o
);

    chan_state_t st_d, st_q;
    logic        latch_en, follow_en;

    clamp_mode_decode dec_i (
        .mode_i      (st_q.mode),
        .gate_src_i  (alarm_gate_i),
        .latch_en_o  (latch_en),
        .follow_en_o (follow_en)
    );

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            // Rewrite has priority over any alarm in the same cycle.
            st_d.mode    = clamp_mode_e'(wr_mode_i);
            st_d.latched = 1'b0;
            st_d.clamp   = safe_i;
        end else begin
            st_d.latched = st_q.latched | (alarm_i & latch_en);
            st_d.clamp   = safe_i | st_d.latched | (alarm_i & follow_en);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_OFF, latched: 1'b0, clamp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clamp_o = st_q.clamp;

    assert_safe_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
        safe_i |=> clamp_o);

    assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && !wr_i) |=> clamp_o);

    assert_rewrite_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !safe_i) |=> !clamp_o);

    assert_off_no_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_OFF && !wr_i && !safe_i && !st_q.latched) |=> !clamp_o);

    assert_noalm_no_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_NOALM && !wr_i && !safe_i && !st_q.latched) |=> !clamp_o);

    assert_follow_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_FOLLOW && !alarm_gate_i && !wr_i && !st_q.latched)
            |=> (clamp_o == $past(alarm_i | safe_i)));

endmodule

// File: rtl/clamp_ctl_top.sv
module clamp_ctl_top #(
    parameter int NCH = 2,
    localparam int MW = 2 * NCH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] safe_i,
    input  logic [NCH-1:0] alarm_i,
    input  logic [NCH-1:0] alarm_gate_i,
    input  logic [NCH-1:0] cfg_wr_i,
    input  logic [MW-1:0]  cfg_mode_i,
    output logic [NCH-1:0] clamp_o
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        clamp_chan_core core_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .safe_i       (safe_i[c]),
            .alarm_i      (alarm_i[c]),
            .alarm_gate_i (alarm_gate_i[c]),
            .wr_i         (cfg_wr_i[c]),
            .wr_mode_i    (cfg_mode_i[2*c +: 2]),
            .clamp_o      (clamp_o[c])
        );
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (clamp_o == '0));

endmodule

// File: tb/clamp_ctl_top_tb_top.sv
module clamp_ctl_top_tb_top;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] safe_i, alarm_i, alarm_gate_i, cfg_wr_i;
    logic [2*NCH-1:0] cfg_mode_i;
    logic [NCH-1:0] clamp_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    clamp_ctl_top #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .safe_i(safe_i), .alarm_i(alarm_i),
        .alarm_gate_i(alarm_gate_i), .cfg_wr_i(cfg_wr_i),
        .cfg_mode_i(cfg_mode_i), .clamp_o(clamp_o)
    );

    // Requirement-level model
    logic [1:0] m_mode [NCH];
    logic       m_lat  [NCH];

    typedef struct {
        logic [NCH-1:0] exp;
        string          tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    task automatic check_front();
        sb_item_t it;
        if (sb_q.size() == 0) return;
        it = sb_q.pop_front();
        for (int c = 0; c < NCH; c++) begin
            n_run++;
            if (clamp_o[c] !== it.exp[c]) begin
                n_fail++;
                $display("FAIL %s ch%0d: clamp_o actual=%b expected=%b",
                         it.tag, c, clamp_o[c], it.exp[c]);
            end
        end
    endtask

    // One cycle of stimulus; the expected output is due one edge later.
    task automatic step(input logic [NCH-1:0] safe, input logic [NCH-1:0] alm,
                        input logic [NCH-1:0] gate, input logic [NCH-1:0] wr,
                        input logic [2*NCH-1:0] mode, input string tag);
        sb_item_t it;
        @(negedge clk);
        check_front();
        safe_i = safe; alarm_i = alm; alarm_gate_i = gate;
        cfg_wr_i = wr; cfg_mode_i = mode;
        for (int c = 0; c < NCH; c++) begin
            if (wr[c]) begin
                m_mode[c] = mode[2*c +: 2];
                m_lat[c]  = 1'b0;
                it.exp[c] = safe[c];
            end else begin
                if (alm[c] && (m_mode[c] == 2'd3 || (m_mode[c] == 2'd2 && gate[c])))
                    m_lat[c] = 1'b1;
                it.exp[c] = safe[c] | m_lat[c] |
                            (alm[c] & ~gate[c] & (m_mode[c] == 2'd2));
            end
        end
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input logic [NCH-1:0] alm, input logic [NCH-1:0] gate,
                        input string tag);
        step('0, alm, gate, '0, '0, tag);
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin m_mode[c] = 2'd0; m_lat[c] = 1'b0; end
        rst_n = 1'b0; safe_i = '0; alarm_i = '0; alarm_gate_i = '0;
        cfg_wr_i = '0; cfg_mode_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (clamp_o !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: clamp_o actual=%b expected=00", clamp_o);
        end
        rst_n = 1'b1;

        // R1/R2: mode 0 after reset, alarms do nothing
        idle(2'b11, 2'b00, "R1 R2 mode0 alarm");
        idle(2'b11, 2'b11, "R2 mode0 gate alarm");
        // R3: mode 1 on both
        step('0, '0, '0, 2'b11, 4'b0101, "R3 write mode1");
        idle(2'b11, 2'b00, "R3 mode1 alarm");
        idle(2'b11, 2'b11, "R3 mode1 gate alarm");
        // R4: ch0 mode 3, ch1 stays mode 1 (R10)
        step('0, '0, '0, 2'b01, 4'b0111, "R4 write mode3 ch0");
        idle(2'b01, 2'b00, "R4 R10 alarm ch0");
        idle(2'b00, 2'b00, "R4 hold after clear");
        idle(2'b00, 2'b00, "R4 hold again");
        idle(2'b10, 2'b00, "R10 ch1 alarm no effect");
        // R5: rewrite mode 3 releases
        step('0, '0, '0, 2'b01, 4'b0111, "R5 rewrite 3 releases");
        idle(2'b00, 2'b00, "R5 stays released");
        idle(2'b01, 2'b00, "R4 relatch");
        step('0, '0, '0, 2'b01, 4'b0101, "R5 rewrite 1 releases");
        idle(2'b01, 2'b00, "R3 R5 mode1 after release");
        // R6: mode 2 follow on both
        step('0, '0, '0, 2'b11, 4'b1010, "R6 write mode2");
        idle(2'b11, 2'b00, "R6 follow high");
        idle(2'b00, 2'b00, "R6 follow release");
        idle(2'b01, 2'b00, "R6 R10 follow ch0 only");
        // R7: gate-sourced alarm latches in mode 2
        idle(2'b10, 2'b10, "R7 gate alarm ch1");
        idle(2'b00, 2'b00, "R7 held after clear");
        idle(2'b01, 2'b00, "R7 R10 ch0 follow, ch1 held");
        idle(2'b00, 2'b00, "R7 held");
        step('0, '0, '0, 2'b10, 4'b1000, "R5 release ch1");
        // R9: rewrite concurrent with alarm
        step('0, 2'b11, 2'b00, 2'b01, 4'b1011, "R9 write+alarm ch0");
        idle(2'b00, 2'b00, "R9 no latch after");
        idle(2'b01, 2'b00, "R4 latch after R9");
        // R8: safe pins override
        step(2'b11, '0, '0, '0, '0, "R8 safe both");
        step(2'b10, '0, '0, 2'b11, 4'b0000, "R8 safe over write");
        step(2'b10, 2'b10, '0, '0, '0, "R8 safe over mode0");
        idle(2'b00, 2'b00, "R8 safe released");
        step('0, '0, '0, 2'b01, 4'b0011, "R2 write mode3 ch0");
        idle(2'b01, 2'b00, "R4 latch");
        step(2'b01, '0, '0, '0, '0, "R8 safe while latched");
        idle(2'b00, 2'b00, "R8 latch kept after safe");
        step('0, '0, '0, 2'b01, 4'b0000, "R5 release to mode0");
        idle(2'b00, 2'b00, "final");
        @(negedge clk);
        check_front();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule